// File: doc/BRIEF.md
# Two-Wire Debug Register Port (Slave Side)

This block is the target end of a serial debug link made of one clock line and one bidirectional data line. An external master uses it to read and write a small register space inside the chip. Both link lines are brought into the system clock domain through a flip-flop synchronizer, and all edges and conditions are detected there. A command opens with a start condition. A header byte follows, made of a register address and a direction bit. After that the master moves any number of data bytes. A single separator bit follows every byte.

The separator bit has two jobs. A separator sampled high arms the port for a new start condition and lets the processor accept external bus requests again. A separator sampled low keeps the bus held and makes the port ignore start conditions. When no start arrives after a byte, the same operation carries on at the next register address. Reads and writes to one address reach different registers: reads return fixed identification bytes, and writes load bytes that leave the block on a parallel bus for the breakpoint logic.

Top module: `dbg_link_slave`

## Requirements
- R1: After reset the data line is released (`link_dat_oe` = 0), `bus_hold_o` is 0, every write-only byte is 0, and the port is armed to accept a start condition.
- R2: A start condition is a falling data line while the clock line stays high. It is accepted only after reset or after a separator sampled as 1, and a start seen at any other time changes nothing.
- R3: After a start, the first byte is the header, most significant bit first: bits 7..1 are the register address and bit 0 is the direction (0 = write, 1 = read). One separator bit follows.
- R4: In a write command, each data byte is shifted in most significant bit first and is stored when its separator is sampled. Address n for n < 4 loads byte n of `wr_bank_o` (bits 8n+7..8n). Addresses 00h–02h hold the breakpoint match value, low byte first. Writes to any other address are dropped.
- R5: In a read command, the slave drives the 8 data bits most significant bit first. Each bit changes after a falling clock edge, so the master samples it on the next rising edge.
- R6: Read-only and write-only registers share addresses. A read returns 3Ch at 00h, 5Ah at 01h, 02h at 02h and 00h everywhere else, whatever was written there.
- R7: Without a new start, each further byte continues the same operation at the address plus one, wrapping from 7Fh to 00h.
- R8: The slave drives the data line only during the 8 data bits of a read. It releases the line for header bits, for every separator, and while idle.
- R9: `bus_hold_o` is 1 while `breq_en_i` is 1 and a command is open whose latest separator was 0 (or has not come yet). It drops once a separator of 1 is sampled, and it is 0 whenever `breq_en_i` is 0.
- R10: An accepted start aborts a byte in progress. Its partial bits are discarded and the bit count restarts at the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk_i | input | 1 | Link clock line from the master (asynchronous) |
| link_dat_i | input | 1 | Link data line as seen at the pad (asynchronous) |
| link_dat_o | output | 1 | Data value driven during read bits |
| link_dat_oe | output | 1 | Output enable for the data line |
| breq_en_i | input | 1 | External bus requests are enabled |
| bus_hold_o | output | 1 | Keeps the processor from granting external bus requests |
| wr_bank_o | output | 32 | Write-only register contents, byte n at bits 8n+7..8n |

## Verification
The separator sample is the one cycle where several functions meet. In that cycle the byte is committed to a write-only register, the address steps, the next read byte is loaded, the hold output changes and the port is armed or disarmed for a start. The bench reaches this cycle with chained writes and reads that alternate separators of 0 and 1, with a start attempted right after a 0 separator, and with a start that cuts a byte short after a 1 separator. A behavioural model runs in step with the design and judges the data enable, the driven bit, the hold output and the register bank on every clock. Directed checks add the bytes the master captures and the final register contents.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    localparam int DW      = 8;
    localparam int AW      = DW - 1;
    localparam int CW      = $clog2(DW + 1);
    localparam int SEP_CNT = DW;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   sr;
        logic [AW-1:0]   addr;
        logic            rd;
        logic            armed;
        logic            hold;
        logic [DW-1:0]   tx;
        logic            oe;
        logic            dout;
    } link_state_t;

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_dat,
    output logic clk_rise,
    output logic clk_fall,
    output logic start_cond,
    output logic dat_s
);

    logic [STAGES:0][1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = {line_clk, line_dat};
        for (int i = 1; i <= STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    logic cur_c, cur_d, prv_c, prv_d;
    assign cur_c = stg_q[STAGES-1][1];
    assign cur_d = stg_q[STAGES-1][0];
    assign prv_c = stg_q[STAGES][1];
    assign prv_d = stg_q[STAGES][0];

    assign clk_rise   = cur_c & ~prv_c;
    assign clk_fall   = ~cur_c & prv_c;
    assign start_cond = cur_c & prv_c & prv_d & ~cur_d;
    assign dat_s      = cur_d;

endmodule

// File: rtl/link_fsm.sv
module link_fsm
    import dbg_link_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_rise,
    input  logic          clk_fall,
    input  logic          start_cond,
    input  logic          dat_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          dat_o,
    output logic          dat_oe,
    output logic          hold_o,
    output logic          start_acc,
    output phase_e        st_phase,
    output logic          st_rd,
    output logic [CW-1:0] st_cnt,
    output logic          st_armed
);

    link_state_t st_d, st_q;

    assign rd_addr = (st_q.phase == PH_HDR) ? st_q.sr[DW-1:1]
                                            : AW'(st_q.addr + AW'(1));

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        start_acc = start_cond & st_q.armed;

        if (start_acc) begin
            st_d.phase = PH_HDR;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            st_d.hold  = 1'b1;
            st_d.oe    = 1'b0;
            st_d.dout  = 1'b1;
        end else if (clk_rise && st_q.phase != PH_IDLE) begin
            if (st_q.cnt != CW'(SEP_CNT)) begin
                st_d.sr  = {st_q.sr[DW-2:0], dat_s};
                st_d.cnt = CW'(st_q.cnt + CW'(1));
            end else begin
                st_d.cnt   = '0;
                st_d.armed = dat_s;
                st_d.hold  = ~dat_s;
                st_d.tx    = rd_data;
                if (st_q.phase == PH_HDR) begin
                    st_d.phase = PH_DATA;
                    st_d.addr  = st_q.sr[DW-1:1];
                    st_d.rd    = st_q.sr[0];
                end else begin
                    wr_en     = ~st_q.rd;
                    st_d.addr = AW'(st_q.addr + AW'(1));
                end
            end
        end else if (clk_fall) begin
            st_d.oe = (st_q.phase == PH_DATA) && st_q.rd
                      && (st_q.cnt != CW'(SEP_CNT));
            if (st_d.oe) begin
                st_d.dout = st_q.tx[DW-1];
                st_d.tx   = {st_q.tx[DW-2:0], 1'b0};
            end else begin
                st_d.dout = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.armed <= 1'b1;
            st_q.dout  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.sr;
    assign dat_o    = st_q.dout;
    assign dat_oe   = st_q.oe;
    assign hold_o   = st_q.hold;
    assign st_phase = st_q.phase;
    assign st_rd    = st_q.rd;
    assign st_cnt   = st_q.cnt;
    assign st_armed = st_q.armed;

endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
    import dbg_link_pkg::*;
#(
    parameter int          NUM_WR = 4,
    parameter logic [7:0]  ID_LO  = 8'h3C,
    parameter logic [7:0]  ID_HI  = 8'h5A,
    parameter logic [7:0]  REV    = 8'h02
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [NUM_WR*DW-1:0] bank_o
);

    always_comb begin
        case (rd_addr)
            AW'(0):  rd_data = ID_LO;
            AW'(1):  rd_data = ID_HI;
            AW'(2):  rd_data = REV;
            default: rd_data = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_WR; g++) begin : g_wr
        logic [DW-1:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (wr_en && wr_addr == AW'(g)) byte_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end

        assign bank_o[g*DW +: DW] = byte_q;
    end

endmodule

// File: rtl/dbg_link_slave.sv
module dbg_link_slave
    import dbg_link_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_WR      = 4,
    parameter logic [7:0] ID_LO       = 8'h3C,
    parameter logic [7:0] ID_HI       = 8'h5A,
    parameter logic [7:0] REV         = 8'h02
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_clk_i,
    input  logic                 link_dat_i,
    output logic                 link_dat_o,
    output logic                 link_dat_oe,
    input  logic                 breq_en_i,
    output logic                 bus_hold_o,
    output logic [NUM_WR*8-1:0]  wr_bank_o
);

    logic          clk_rise, clk_fall, start_cond, dat_s;
    logic          start_acc, wr_en, hold_raw;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    phase_e        fsm_phase;
    logic          fsm_rd, fsm_armed;
    logic [CW-1:0] fsm_cnt;

    link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_clk   (link_clk_i),
        .line_dat   (link_dat_i),
        .clk_rise   (clk_rise),
        .clk_fall   (clk_fall),
        .start_cond (start_cond),
        .dat_s      (dat_s)
    );

    link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_rise   (clk_rise),
        .clk_fall   (clk_fall),
        .start_cond (start_cond),
        .dat_s      (dat_s),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dat_o      (link_dat_o),
        .dat_oe     (link_dat_oe),
        .hold_o     (hold_raw),
        .start_acc  (start_acc),
        .st_phase   (fsm_phase),
        .st_rd      (fsm_rd),
        .st_cnt     (fsm_cnt),
        .st_armed   (fsm_armed)
    );

    dbg_regs #(
        .NUM_WR (NUM_WR),
        .ID_LO  (ID_LO),
        .ID_HI  (ID_HI),
        .REV    (REV)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_o  (wr_bank_o)
    );

    assign bus_hold_o = breq_en_i & hold_raw;

endmodule

// File: rtl/dbg_link_chk.sv
module dbg_link_chk
    import dbg_link_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          link_dat_oe,
    input logic          bus_hold_o,
    input logic          breq_en_i,
    input logic          wr_en,
    input phase_e        phase,
    input logic          rd,
    input logic [CW-1:0] cnt,
    input logic          armed,
    input logic          start_cond,
    input logic          start_acc
);

    p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_dat_oe |-> (phase == PH_DATA && rd));

    p_oe_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_dat_oe) |-> (cnt == '0));

    p_write_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (phase == PH_DATA && !rd && cnt == CW'(SEP_CNT)));

    p_start_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (phase == PH_HDR && cnt == '0));

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cond && !armed) |=> ($stable(phase) && $stable(cnt)));

    p_hold_in_header_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_en_i && phase == PH_HDR) |-> bus_hold_o);

endmodule

bind dbg_link_slave dbg_link_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_dat_oe (link_dat_oe),
    .bus_hold_o  (bus_hold_o),
    .breq_en_i   (breq_en_i),
    .wr_en       (wr_en),
    .phase       (fsm_phase),
    .rd          (fsm_rd),
    .cnt         (fsm_cnt),
    .armed       (fsm_armed),
    .start_cond  (start_cond),
    .start_acc   (start_acc)
);

// File: tb/sim_dbg_link_slave.sv
`timescale 1ns/1ps
module sim_dbg_link_slave;

    localparam int H      = 8;
    localparam int NUM_WR = 4;
    localparam logic [7:0] ID_LO = 8'h3C;
    localparam logic [7:0] ID_HI = 8'h5A;
    localparam logic [7:0] REV   = 8'h02;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n   = 1'b0;
    logic lclk    = 1'b1;
    logic mdrv    = 1'b1;
    logic breq_en = 1'b0;
    logic dut_o, dut_oe, dut_hold;
    logic [NUM_WR*8-1:0] dut_bank;
    wire  line = dut_oe ? dut_o : mdrv;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    dbg_link_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_clk_i  (lclk),
        .link_dat_i  (line),
        .link_dat_o  (dut_o),
        .link_dat_oe (dut_oe),
        .breq_en_i   (breq_en),
        .bus_hold_o  (dut_hold),
        .wr_bank_o   (dut_bank)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ro_val(input logic [6:0] a);
        case (a)
            7'd0:    return ID_LO;
            7'd1:    return ID_HI;
            7'd2:    return REV;
            default: return 8'h00;
        endcase
    endfunction

    // behavioural reference: samples lag the pad by the synchronizer depth
    logic [1:0] hq [3];
    int         mph, mcnt;
    logic [7:0] msr, mtx;
    logic [6:0] maddr;
    logic       mrw, marm, mhold, moe, mdout, mline;
    logic [31:0] mbank;
    logic       c2, d2, c3, d3;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hq[i] = 2'b11;
            mph = 0; mcnt = 0; msr = 0; mtx = 0; maddr = 0; mrw = 0;
            marm = 1; mhold = 0; moe = 0; mdout = 1; mbank = 0;
        end else begin
            mline = moe ? mdout : mdrv;
            c2 = hq[1][1]; d2 = hq[1][0];
            c3 = hq[2][1]; d3 = hq[2][0];
            if (c2 && c3 && d3 && !d2 && marm) begin
                mph = 1; mcnt = 0; marm = 0; mhold = 1; moe = 0; mdout = 1;
            end else if (c2 && !c3 && mph != 0) begin
                if (mcnt < 8) begin
                    msr = {msr[6:0], d2};
                    mcnt++;
                end else begin
                    mcnt = 0; marm = d2; mhold = !d2;
                    if (mph == 1) begin
                        maddr = msr[7:1]; mrw = msr[0]; mph = 2;
                    end else begin
                        if (!mrw && int'(maddr) < NUM_WR) mbank[int'(maddr)*8 +: 8] = msr;
                        maddr = maddr + 7'd1;
                    end
                    mtx = ro_val(maddr);
                end
            end else if (!c2 && c3) begin
                moe = (mph == 2) && mrw && (mcnt < 8);
                if (moe) begin
                    mdout = mtx[7];
                    mtx = {mtx[6:0], 1'b0};
                end else begin
                    mdout = 1;
                end
            end
            hq[2] = hq[1]; hq[1] = hq[0]; hq[0] = {lclk, mline};
        end
    end

    always @(posedge clk) begin
        if (rst_n && !done) begin
            #1;
            check("R8 data enable vs model", {31'd0, dut_oe}, {31'd0, moe});
            if (moe) check("R5 driven bit vs model", {31'd0, dut_o}, {31'd0, mdout});
            check("R9 hold vs model", {31'd0, dut_hold}, {31'd0, breq_en & mhold});
            check("R4 register bank vs model", dut_bank, mbank);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic got);
        lclk = 1'b0;
        wait_n(2);
        mdrv = b;
        wait_n(H - 2);
        lclk = 1'b1;
        wait_n(H);
        got = line;
    endtask

    task automatic xfer(input logic [7:0] v, input logic sep, output logic [7:0] got);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            bit_x(v[i], g);
            got[i] = g;
        end
        bit_x(sep, g);
    endtask

    task automatic do_start();
        if (!(lclk && mdrv)) begin
            lclk = 1'b0; wait_n(2);
            mdrv = 1'b1; wait_n(H);
            lclk = 1'b1; wait_n(H);
        end
        mdrv = 1'b0;
        wait_n(H);
    endtask

    initial begin
        logic [7:0] g;
        logic       b;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        breq_en = 1'b1;
        wait_n(1);
        check("R1 enable after reset", {31'd0, dut_oe}, 32'd0);
        check("R1 hold after reset", {31'd0, dut_hold}, 32'd0);
        check("R1 bank after reset", dut_bank, 32'd0);

        // chained write from 00h, separators 0,0,0,0,1
        do_start();
        xfer({7'h00, 1'b0}, 1'b0, g);
        check("R9 hold after header sep 0", {31'd0, dut_hold}, 32'd1);
        xfer(8'hA1, 1'b0, g);
        xfer(8'hB2, 1'b0, g);
        xfer(8'hC3, 1'b0, g);
        xfer(8'hD4, 1'b1, g);
        check("R4 R7 chained write bank", dut_bank, 32'hD4C3B2A1);
        check("R9 hold released by sep 1", {31'd0, dut_hold}, 32'd0);

        // read from 00h: identification, not written data
        do_start();
        xfer({7'h00, 1'b1}, 1'b0, g);
        check("R8 released after header", {31'd0, dut_oe}, 32'd0);
        xfer(8'hFF, 1'b0, g);
        check("R5 R6 read 00h", {24'd0, g}, {24'd0, ID_LO});
        xfer(8'hFF, 1'b0, g);
        check("R7 read 01h", {24'd0, g}, {24'd0, ID_HI});
        xfer(8'hFF, 1'b1, g);
        check("R3 read 02h", {24'd0, g}, {24'd0, REV});

        // read wrap 7Fh -> 00h
        do_start();
        xfer({7'h7F, 1'b1}, 1'b0, g);
        xfer(8'hFF, 1'b0, g);
        check("R6 read unmapped 7Fh", {24'd0, g}, 32'd0);
        xfer(8'hFF, 1'b1, g);
        check("R7 read wraps to 00h", {24'd0, g}, {24'd0, ID_LO});

        // write wrap 7Eh,7Fh dropped, then 00h
        do_start();
        xfer({7'h7E, 1'b0}, 1'b0, g);
        xfer(8'h11, 1'b0, g);
        xfer(8'h22, 1'b0, g);
        xfer(8'h33, 1'b1, g);
        check("R7 write wraps to 00h", dut_bank, 32'hD4C3B233);

        // start after separator 0 is ignored
        do_start();
        xfer({7'h01, 1'b0}, 1'b0, g);
        xfer(8'h55, 1'b0, g);
        mdrv = 1'b1; wait_n(H);
        mdrv = 1'b0; wait_n(H);
        check("R2 R9 hold kept after ignored start", {31'd0, dut_hold}, 32'd1);
        xfer(8'h66, 1'b1, g);
        check("R2 ignored start continues data", dut_bank, 32'hD4665533);

        // start aborts a partial byte
        do_start();
        xfer({7'h03, 1'b0}, 1'b1, g);
        check("R9 hold low while chaining after sep 1", {31'd0, dut_hold}, 32'd0);
        xfer(8'h77, 1'b1, g);
        bit_x(1'b1, b);
        bit_x(1'b0, b);
        bit_x(1'b1, b);
        do_start();
        xfer({7'h02, 1'b1}, 1'b1, g);
        xfer(8'hFF, 1'b1, g);
        check("R10 header after abort", {24'd0, g}, {24'd0, REV});
        check("R10 partial byte discarded", dut_bank, 32'h77665533);

        // bus requests disabled
        breq_en = 1'b0;
        do_start();
        xfer({7'h00, 1'b0}, 1'b0, g);
        check("R9 hold low with enable low", {31'd0, dut_hold}, 32'd0);
        breq_en = 1'b1;
        wait_n(1);
        check("R9 hold follows enable", {31'd0, dut_hold}, 32'd1);
        xfer(8'hAA, 1'b1, g);
        check("R9 hold low after sep 1", {31'd0, dut_hold}, 32'd0);
        check("R4 write after enable toggle", dut_bank, 32'h776655AA);

        wait_n(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule